// File: doc/BRIEF.md
# Ratio-Duty Carrier PWM Generator

This block makes the low-side switching waveform for a motor bridge leg when speed is set by an analog level rather than by a pulse train. It runs a free carrier of `PERIOD` clocks, about 25 kHz with the default 50 MHz clock and 2000-clock period. In each carrier period it drives the low-side gate on for a fraction of the period equal to a reference code divided by a supply code. The codes come from converters outside the block. The high side of the active leg stays on for the whole time; only the low side is switched by `pwm_low`.

The ratio is computed without a combinational divider. At the first clock of every carrier period the block samples both codes and classifies them. It then starts a bit-serial restoring division of `ref_code * PERIOD` by `sup_code`. The result is latched at the last clock of the period and governs the whole of the next period. A period therefore never changes its on-time while it is running.

A reference below the minimum usable code `REF_MIN` gives no on-time at all. A reference at or above the supply gives a gate that is on for the whole period. Deasserting `en` forces the output low and restarts the carrier. The parameters must satisfy `PERIOD >= CODE_W + clog2(PERIOD+1) + 2`, so that the division finishes inside one period.

Top module: `duty_pwm_gen`

## Requirements
- R1: While `en` is high the carrier repeats every `PERIOD` clocks. In each period the output is high for one contiguous run that begins at the first slot of the period, with no other high slot.
- R2: When `REF_MIN <= ref_code < sup_code`, the number of high clocks per period is floor(`ref_code` * `PERIOD` / `sup_code`).
- R3: When `ref_code < REF_MIN`, the output stays low for the whole period, whatever `sup_code` is.
- R4: When `ref_code >= REF_MIN` and `ref_code >= sup_code` (equality included, and a zero supply included), the output is high for all `PERIOD` clocks of the period.
- R5: The codes are sampled only at the first clock of a period, and the result governs the following period. A change of the codes at any other time alters neither the current period nor the next.
- R6: When `en` is low, the output is low from the next clock on and the carrier restarts. The first period after `en` rises has no high clock.
- R7: While `rst_n` is low the output is low.
- R8: The serial division completes before the last clock of the period in which it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the output off and the carrier at its start |
| ref_code | input | CODE_W | Unsigned reference level code |
| sup_code | input | CODE_W | Unsigned supply level code |
| pwm_low | output | 1 | Low-side gate drive, high means switch on |

## Verification
The bench sweeps every pair of 4-bit reference and supply codes in a 20-clock-period configuration. It compares each period's slot pattern against the arithmetic ratio, so a divider that drops a quotient bit or rounds up shows up as a wrong slot count. The sweep covers the boundaries: the minimum-code clamp, reference equal to supply, reference above supply, and a zero supply. A design that ordered the two clamps wrongly, or divided by zero, would give on-times there that differ from the expected ones.

Codes are changed in the middle of a period to catch a design that reads live inputs during the division or latches the result early; such a design would shift the on-time by a period. The bench also checks that the output drops one clock after disable and that a freshly enabled carrier starts with an empty period.

// File: rtl/duty_pwm_gen_pkg.sv
package duty_pwm_gen_pkg;

  // How a sampled code pair turns into an on-time.
  typedef enum logic [1:0] {
    DUTY_ZERO = 2'd0,
    DUTY_FULL = 2'd1,
    DUTY_DIV  = 2'd2
  } duty_kind_e;

  // The minimum-code clamp wins over the full-on clamp; only a reference
  // strictly below the supply needs the divider.
  function automatic duty_kind_e classify_duty(input int unsigned r,
                                               input int unsigned s,
                                               input int unsigned rmin);
    if (r < rmin)  return DUTY_ZERO;
    if (r >= s)    return DUTY_FULL;
    return DUTY_DIV;
  endfunction

endpackage

// File: rtl/pwmgen_carrier.sv
module pwmgen_carrier #(
  parameter int PERIOD = 2000,
  localparam int CNT_W = $clog2(PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign start_o = en && (cnt_q == '0);
  assign last_o  = en && (cnt_q == LAST);

endmodule

// File: rtl/pwmgen_classify.sv
module pwmgen_classify
  import duty_pwm_gen_pkg::*;
#(
  parameter int          CODE_W  = 10,
  parameter int unsigned REF_MIN = 256
) (
  input  logic [CODE_W-1:0] ref_i,
  input  logic [CODE_W-1:0] sup_i,
  output duty_kind_e        kind_o
);

  always_comb begin
    kind_o = classify_duty(32'(ref_i), 32'(sup_i), REF_MIN);
  end

endmodule

// File: rtl/pwmgen_seqdiv.sv
module pwmgen_seqdiv #(
  parameter int NUM_W = 21,
  parameter int DEN_W = 10,
  parameter int Q_W   = 11,
  localparam int ITER_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic [Q_W-1:0]   quo_o
);

  logic [NUM_W-1:0]  num_q;   // dividend bits shift out, quotient bits shift in
  logic [DEN_W-1:0]  den_q;
  logic [DEN_W:0]    rem_q;
  logic [ITER_W-1:0] iter_q;

  logic [DEN_W:0]    rem_shift;
  logic              take;
  logic [DEN_W:0]    rem_next;

  always_comb begin
    rem_shift = {rem_q[DEN_W-1:0], num_q[NUM_W-1]};
    take      = (rem_shift >= {1'b0, den_q});
    rem_next  = take ? (rem_shift - {1'b0, den_q}) : rem_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      iter_q <= '0;
    end else if (start_i) begin
      num_q  <= num_i;
      den_q  <= den_i;
      rem_q  <= '0;
      iter_q <= ITER_W'(NUM_W);
    end else if (iter_q != '0) begin
      num_q  <= {num_q[NUM_W-2:0], take};
      rem_q  <= rem_next;
      iter_q <= iter_q - 1'b1;
    end
  end

  // The quotient is below PERIOD whenever it is used, so the high bits are zero.
  logic unused_quo_hi;
  assign unused_quo_hi = ^num_q[NUM_W-1:Q_W];

  assign busy_o = (iter_q != '0);
  assign quo_o  = num_q[Q_W-1:0];

endmodule

// File: rtl/duty_pwm_gen.sv
module duty_pwm_gen
  import duty_pwm_gen_pkg::*;
#(
  parameter int          CODE_W  = 10,
  parameter int          PERIOD  = 2000,
  parameter int unsigned REF_MIN = 256,
  localparam int CNT_W = $clog2(PERIOD + 1),
  localparam int NUM_W = CODE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] ref_code,
  input  logic [CODE_W-1:0] sup_code,
  output logic              pwm_low
);

  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0] cnt;
  logic             period_start;
  logic             period_last;
  logic             div_busy;
  logic [CNT_W-1:0] div_quo;
  logic [CNT_W-1:0] on_len_q;

  duty_kind_e       kind_now;
  duty_kind_e       kind_q;
  logic [NUM_W-1:0] dividend;
  logic             pwm_q;

  pwmgen_carrier #(.PERIOD(PERIOD)) u_carrier (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .cnt_o   (cnt),
    .start_o (period_start),
    .last_o  (period_last)
  );

  pwmgen_classify #(.CODE_W(CODE_W), .REF_MIN(REF_MIN)) u_classify (
    .ref_i  (ref_code),
    .sup_i  (sup_code),
    .kind_o (kind_now)
  );

  assign dividend = NUM_W'(ref_code) * NUM_W'(PERIOD);

  pwmgen_seqdiv #(.NUM_W(NUM_W), .DEN_W(CODE_W), .Q_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (period_start),
    .num_i   (dividend),
    .den_i   (sup_code),
    .busy_o  (div_busy),
    .quo_o   (div_quo)
  );

  // Snapshot the clamp decision together with the divider operands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= DUTY_ZERO;
    end else if (period_start) begin
      kind_q <= kind_now;
    end
  end

  // On-time changes only at a period boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_len_q <= '0;
    end else if (!en) begin
      on_len_q <= '0;
    end else if (period_last) begin
      unique case (kind_q)
        DUTY_FULL: on_len_q <= CNT_W'(PERIOD);
        DUTY_DIV:  on_len_q <= div_quo;
        default:   on_len_q <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= en && (cnt < on_len_q);
    end
  end

  assign pwm_low = pwm_q;

endmodule

// File: rtl/duty_pwm_gen_chk.sv
module duty_pwm_gen_chk #(
  parameter int PERIOD = 2000,
  parameter int CNT_W  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pwm_low,
  input logic             period_start,
  input logic             period_last,
  input logic             div_busy,
  input logic [CNT_W-1:0] on_len_q
);

  // R1: a high run can only begin right after the first slot of a period.
  a_r1_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_low) |-> $past(period_start));

  // R4: the latched on-time never exceeds the carrier period.
  a_r4_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    on_len_q <= CNT_W'(PERIOD));

  // R5: the on-time is held everywhere except at the last slot.
  a_r5_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_last) |=> $stable(on_len_q));

  // R6: disable forces the output low on the next clock.
  a_r6_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_low);

  // R8: the divider is idle by the time its result is latched.
  a_r8_div_in_time: assert property (@(posedge clk) disable iff (!rst_n)
    period_last |-> !div_busy);

  // R7: output low during reset.
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r7_low_in_reset: assert (!pwm_low);
    end
  end

endmodule

bind duty_pwm_gen duty_pwm_gen_chk #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .pwm_low      (pwm_low),
  .period_start (period_start),
  .period_last  (period_last),
  .div_busy     (div_busy),
  .on_len_q     (on_len_q)
);

// File: tb/duty_pwm_gen_tb.sv
module duty_pwm_gen_tb;

  localparam int P    = 20;
  localparam int CW   = 4;
  localparam int RMIN = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [CW-1:0] ref_c = '0;
  logic [CW-1:0] sup_c = '0;
  logic          pwm;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  duty_pwm_gen #(.CODE_W(CW), .PERIOD(P), .REF_MIN(RMIN)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ref_code (ref_c),
    .sup_code (sup_c),
    .pwm_low  (pwm)
  );

  // Expected high clocks per period, from the requirements.
  function automatic int exp_len(input int r, input int s);
    if (r < RMIN) return 0;        // R3
    if (r >= s)   return P;        // R4
    return (r * P) / s;            // R2
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Observe slots s0..s1-1 of a period; slot s must be high iff s < len.
  task automatic seg(input int len, input int s0, input int s1,
                     inout int hi, inout int bad);
    for (int s = s0; s < s1; s++) begin
      tick();
      if (pwm) hi++;
      if (pwm != (s < len)) bad++;
    end
  endtask

  // Disable, load the codes, and enable just before slot 0 of period 0.
  task automatic restart(input int r, input int s);
    en = 1'b0;
    tick();
    tick();
    ref_c = CW'(r);
    sup_c = CW'(s);
    en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hi, bad, first_bad, exp;
    string tag;

    // R7: reset state.
    tick();
    check(pwm == 1'b0, "R7 reset", pwm, 0);
    tick();
    rst_n = 1'b1;
    tick();
    tick();
    check(pwm == 1'b0, "R7 idle after reset", pwm, 0);

    // Full sweep of both codes: R2, R3, R4, R8; first period empty (R6).
    first_bad = 0;
    for (int r = 0; r < (1 << CW); r++) begin
      for (int s = 0; s < (1 << CW); s++) begin
        restart(r, s);
        hi = 0; bad = 0;
        seg(0, 0, P, hi, bad);
        first_bad += bad;
        exp = exp_len(r, s);
        hi = 0; bad = 0;
        seg(exp, 0, P, hi, bad);
        if (r < RMIN)    tag = "R3 min clamp";
        else if (r >= s) tag = "R4 full clamp";
        else             tag = "R2 R8 ratio";
        check(bad == 0, tag, hi, exp);
      end
    end
    check(first_bad == 0, "R6 first period empty", first_bad, 0);

    // R1: two consecutive periods with the same contiguous run.
    restart(3, 4);
    hi = 0; bad = 0;
    seg(0, 0, P, hi, bad);
    hi = 0; bad = 0;
    seg(15, 0, P, hi, bad);
    seg(15, 0, P, hi, bad);
    check(bad == 0 && hi == 30, "R1 period repeat", hi, 30);

    // R5: mid-period code changes take effect only via the next sample.
    restart(9, 12);                 // A: 15
    hi = 0; bad = 0;
    seg(0, 0, 5, hi, bad);
    ref_c = 4'd4; sup_c = 4'd8;     // B: 10
    seg(0, 5, P, hi, bad);
    hi = 0; bad = 0;
    seg(15, 0, 5, hi, bad);
    ref_c = 4'd5; sup_c = 4'd15;    // C: 6
    seg(15, 5, P, hi, bad);
    check(bad == 0 && hi == 15, "R5 period keeps first sample", hi, 15);
    hi = 0; bad = 0;
    seg(10, 0, P, hi, bad);
    check(bad == 0 && hi == 10, "R5 second sample applied", hi, 10);
    hi = 0; bad = 0;
    seg(6, 0, P, hi, bad);
    check(bad == 0 && hi == 6, "R5 third sample applied", hi, 6);

    // R6: disable mid-run drops the output on the next clock.
    restart(12, 12);
    hi = 0; bad = 0;
    seg(0, 0, P, hi, bad);
    seg(P, 0, 7, hi, bad);
    check(pwm == 1'b1, "R6 running before disable", pwm, 1);
    en = 1'b0;
    tick();
    check(pwm == 1'b0, "R6 off after disable", pwm, 0);
    hi = 0;
    for (int k = 0; k < 2 * P; k++) begin
      tick();
      if (pwm) hi++;
    end
    check(hi == 0, "R6 stays off while disabled", hi, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule